// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

A purely combinational shift unit for a 32-bit processor datapath. It takes an operand and moves it by a shift amount in one of three ways: logical left, logical right or rotate right. At the same time it works out the carry flag that a flag-setting instruction would write back. The amount is 8 bits wide, so a value read from a register (0 to 255) can be applied directly, not only a 5-bit immediate.

The carry logic follows exact rules. A zero amount leaves the carry alone. Logical shifts of 32 or more clear the result. Logical shifts of 33 or more clear the carry when flags are written. Rotation wraps the amount modulo 32. When the flag-update input is low, the incoming carry always passes straight through.

Inside, one rotate-right network serves all three operations. A left shift reverses the bit order before the network and again after it. The logical shifts mask off the bits that wrapped around. The carry-out of every shifting operation is then the top bit of the rotator output.

Top module: `barrel_shift_carry`

## Requirements
- R1: With shift_kind 2'b00 (logical left) and an amount n from 1 to 31, result bit i equals operand bit i-n for i >= n, and is 0 for i < n.
- R2: With shift_kind 2'b00, flag_update high and an amount n from 1 to 32, carry_out equals operand bit 32-n.
- R3: With an amount of 0 and any shift_kind, result equals operand and carry_out equals carry_in.
- R4: With shift_kind 2'b00 or 2'b01 and an amount of 32 or more, every result bit is 0.
- R5: With shift_kind 2'b00 or 2'b01, flag_update high and an amount of 33 or more, carry_out is 0.
- R6: With shift_kind 2'b01 (logical right) and an amount n from 1 to 31, result bit i equals operand bit i+n for i+n <= 31, and is 0 otherwise. With flag_update high and n from 1 to 32, carry_out equals operand bit n-1.
- R7: With shift_kind 2'b10 (rotate right) and a nonzero amount n, result bit i equals operand bit (i+n) mod 32. With flag_update high, carry_out equals result bit 31, which is operand bit (n-1) mod 32. For a nonzero multiple of 32, result equals operand and carry_out equals operand bit 31.
- R8: With flag_update low, carry_out equals carry_in for every shift_kind and amount.
- R9: With shift_kind 2'b11 (unused code), result equals operand and carry_out equals carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 32 | Value to be shifted or rotated |
| shamt | input | 8 | Shift amount, 0 to 255 |
| shift_kind | input | 2 | 00 logical left, 01 logical right, 10 rotate right, 11 pass-through |
| carry_in | input | 1 | Current carry flag |
| flag_update | input | 1 | High when the instruction writes the carry flag |
| result | output | 32 | Shifted or rotated operand |
| carry_out | output | 1 | Carry flag to be written |

## Verification
The unit holds no state, so any fault shows at the ports in the same evaluation as the inputs that expose it. A wrongly wired rotator stage corrupts the result only for amounts whose matching bit is set. A wrong mask shows only for logical shifts. A wrong carry choice shows only for particular kinds and amount classes. The bench therefore drives every kind at the amounts 0, 1, 31, 32, 33 and 255, then random operands and amounts. Each output is compared with a bitwise reference model, so each path is checked on its own.

// File: rtl/barrel_shift_carry.sv
module barrel_shift_carry #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic [WIDTH-1:0] operand,
  input  logic [AMT_W-1:0] shamt,
  input  logic [1:0]       shift_kind,
  input  logic             carry_in,
  input  logic             flag_update,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  // WIDTH must be a power of two and below 2**AMT_W
  localparam int LOG_W = $clog2(WIDTH);
  localparam logic [AMT_W-1:0] WIDTH_A = AMT_W'(WIDTH);
  localparam logic [1:0] K_LSL = 2'b00;
  localparam logic [1:0] K_LSR = 2'b01;
  localparam logic [1:0] K_ROR = 2'b10;

  logic [WIDTH-1:0] rev_in, src, rot, rev_out, mask, masked;
  logic [WIDTH-1:0] stage [0:LOG_W];
  logic is_left, is_logical, big;

  assign is_left    = (shift_kind == K_LSL);
  assign is_logical = (shift_kind == K_LSL) || (shift_kind == K_LSR);
  assign big        = |shamt[AMT_W-1:LOG_W];

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_rev
      assign rev_in[i]  = operand[WIDTH-1-i];
      assign rev_out[i] = masked[WIDTH-1-i];
    end
  endgenerate

  assign src      = is_left ? rev_in : operand;
  assign stage[0] = src;

  generate
    for (i = 0; i < LOG_W; i++) begin : g_stage
      localparam int S = 1 << i;
      assign stage[i+1] = shamt[i] ? {stage[i][S-1:0], stage[i][WIDTH-1:S]} : stage[i];
    end
  endgenerate

  assign rot    = stage[LOG_W];
  assign mask   = big ? '0 : ({WIDTH{1'b1}} >> shamt[LOG_W-1:0]);
  assign masked = rot & mask;

  always_comb begin
    if (shamt == '0)             result = operand;
    else if (is_left)            result = rev_out;
    else if (shift_kind == K_LSR) result = masked;
    else if (shift_kind == K_ROR) result = rot;
    else                         result = operand;
  end

  always_comb begin
    if (!flag_update || shamt == '0 || shift_kind == 2'b11) carry_out = carry_in;
    else if (is_logical && shamt > WIDTH_A)                 carry_out = 1'b0;
    else                                                    carry_out = rot[WIDTH-1];
  end

  always_comb begin
    if (shamt == '0)
      p_zero_amount_r3: assert (result == operand && carry_out == carry_in)
        else $error("zero amount altered result or carry");
    if (is_logical && shamt >= WIDTH_A)
      p_large_clears_r4: assert (result == '0)
        else $error("large logical shift left bits set");
    if (is_logical && flag_update && shamt > WIDTH_A)
      p_huge_carry_r5: assert (carry_out == 1'b0)
        else $error("carry not cleared beyond width");
    if (shift_kind == K_ROR && flag_update && shamt != '0)
      p_ror_carry_r7: assert (carry_out == result[WIDTH-1])
        else $error("rotate carry differs from top result bit");
    if (shift_kind == K_ROR && shamt != '0 && shamt[LOG_W-1:0] == '0)
      p_ror_full_r7: assert (result == operand)
        else $error("full rotation changed operand");
    if (!flag_update)
      p_hold_carry_r8: assert (carry_out == carry_in)
        else $error("carry changed without flag update");
    if (shift_kind == 2'b11)
      p_pass_r9: assert (result == operand && carry_out == carry_in)
        else $error("unused kind altered outputs");
  end
endmodule

// File: tb/tb_barrel_shift_carry.sv
module tb_barrel_shift_carry;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] operand, result;
  logic [7:0]  shamt;
  logic [1:0]  shift_kind;
  logic        carry_in, flag_update, carry_out;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  barrel_shift_carry dut (
    .operand(operand), .shamt(shamt), .shift_kind(shift_kind),
    .carry_in(carry_in), .flag_update(flag_update),
    .result(result), .carry_out(carry_out)
  );

  function automatic logic [31:0] ref_res(logic [31:0] x, int n, logic [1:0] k);
    logic [31:0] r = '0;
    if (n == 0 || k == 2'b11) return x;
    for (int i = 0; i < 32; i++) begin
      case (k)
        2'b00: r[i] = (n < 32 && i >= n) ? x[i-n] : 1'b0;
        2'b01: r[i] = (i + n < 32) ? x[i+n] : 1'b0;
        default: r[i] = x[(i + n) % 32];
      endcase
    end
    return r;
  endfunction

  function automatic logic ref_cout(logic [31:0] x, int n, logic [1:0] k, logic ci, logic fe);
    if (!fe || n == 0 || k == 2'b11) return ci;
    case (k)
      2'b00: return (n > 32) ? 1'b0 : x[32-n];
      2'b01: return (n > 32) ? 1'b0 : x[n-1];
      default: return x[(n - 1) % 32];
    endcase
  endfunction

  function automatic string res_tag(int n, logic [1:0] k);
    if (k == 2'b11) return "R9";
    if (n == 0) return "R3";
    if (k != 2'b10 && n >= 32) return "R4";
    if (k == 2'b00) return "R1";
    if (k == 2'b01) return "R6";
    return "R7";
  endfunction

  function automatic string cout_tag(int n, logic [1:0] k, logic fe);
    if (!fe) return "R8";
    if (k == 2'b11) return "R9";
    if (n == 0) return "R3";
    if (k != 2'b10 && n > 32) return "R5";
    if (k == 2'b00) return "R2";
    if (k == 2'b01) return "R6";
    return "R7";
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (op=%h amt=%0d kind=%0d)",
               tag, got, exp, operand, shamt, shift_kind);
    end
  endtask

  task automatic apply(logic [31:0] x, int n, logic [1:0] k, logic ci, logic fe);
    @(negedge clk);
    operand = x; shamt = n[7:0]; shift_kind = k; carry_in = ci; flag_update = fe;
    #3;
    check(res_tag(n, k), result, ref_res(x, n, k));
    check(cout_tag(n, k, fe), {31'b0, carry_out}, {31'b0, ref_cout(x, n, k, ci, fe)});
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    int amts[6] = '{0, 1, 31, 32, 33, 255};
    logic [31:0] pats[4] = '{32'h8000_0001, 32'hA5A5_5A5A, 32'hFFFF_FFFF, 32'h7FFF_FFFE};
    int unused_seed;
    operand = '0; shamt = '0; shift_kind = '0; carry_in = 1'b0; flag_update = 1'b0;
    unused_seed = int'($urandom(32'd2718));
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #3;
    // R3 idle inputs: zero amount passes operand and carry
    check("R3", result, 32'h0);
    check("R3", {31'b0, carry_out}, 32'h0);
    // R1 R2 R4 R5 R6 R7 R8 R9 directed corners
    for (int k = 0; k < 4; k++)
      foreach (amts[a])
        foreach (pats[p]) begin
          apply(pats[p], amts[a], k[1:0], 1'b1, 1'b1);
          apply(pats[p], amts[a], k[1:0], 1'b0, 1'b1);
          apply(pats[p], amts[a], k[1:0], 1'b1, 1'b0);
        end
    // R7 full rotations by nonzero multiples of 32
    apply(32'h8000_0000, 64, 2'b10, 1'b0, 1'b1);
    apply(32'h7FFF_FFFF, 96, 2'b10, 1'b1, 1'b1);
    // R2 R6 boundary bits at every amount 1..32
    for (int n = 1; n <= 32; n++) begin
      apply(32'h1 << (32 - n), n, 2'b00, 1'b0, 1'b1);
      apply(32'h1 << (n - 1), n, 2'b01, 1'b0, 1'b1);
    end
    for (int t = 0; t < 3000; t++) begin
      logic [31:0] x = $urandom;
      int n = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 40);
      logic [1:0] k = 2'($urandom % 4);
      apply(x, n, k, 1'($urandom), ($urandom % 5) != 0);
    end
    done = 1;
    summary();
  end
endmodule